// File: doc/BRIEF.md
# Page Pointer Lookup and Word Fetch Sequencer

This block starts a configuration load from flash. When `start` is pulsed it captures the three-bit page number. It reads that page's pointer record from a fixed option-word window of flash and decodes a starting word address and a length counted in 4-bit nibbles. It then walks the flash word by word from that address and hands each 16-bit word to a downstream serializer over a valid/ready stream. The stream marks the final word and says how many nibbles of that word carry data.

Before any data word is fetched, the pointer record is checked. A record with a zero length, an erased (all ones) length, or a start address inside the boot or option area is rejected. The sequencer then locks in an error state. It ignores further starts and makes no flash reads until reset.

The flash port is a simple synchronous read port. A one-cycle `fl_rd` strobe with `fl_addr` is answered some cycles later by a one-cycle `fl_rvalid` with `fl_rdata`. The block keeps at most one read in flight.

Top module: `pfs_page_fetch`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `out_valid` and `fl_rd` are all low.
- R2: A `start` pulse while idle or done captures `page_sel`. The block reads four option words at addresses 0x008000 + 4*page + k, with k = 0, 1, 2, 3 in that order. `page_sel` is ignored after capture until the sequence ends or reset.
- R3: The pointer is decoded as start = {word1[6:0], word0} (23 bits) and nibble count = {word3[8:0], word2} (25 bits). Bits 15:7 of word1 and bits 15:9 of word3 are ignored.
- R4: At most one flash read is outstanding. No new `fl_rd` is issued until the previous read has returned `fl_rvalid`.
- R5: A pointer is invalid when its count is 0, its count is all ones, or its start is below 0x008020. An invalid pointer raises `error`. `error` then stays high until reset, with no further flash reads, no `out_valid`, and `start` ignored.
- R6: For a valid pointer, data words are read from start, start+1, ... in increasing order. Exactly ceil(count/4) words are read and delivered in read order on `out_data`.
- R7: `out_last` is high only on the final word. `out_nibs` is 4 on every non-final word. On the final word it is count mod 4, or 4 when that remainder is 0.
- R8: Stream rules: once `out_valid` is high it stays high, with `out_data`, `out_last` and `out_nibs` unchanged, until a cycle with `out_ready` high. A word transfers on a clock edge where both are high.
- R9: Two cycles after the final word transfers, `busy` drops and `done` rises. `done` stays high until the next accepted `start`, and a new `start` in that state runs a fresh sequence.
- R10: A `start` pulse while `busy` is high has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a page load (pulse) |
| page_sel | input | 3 | Page number, captured at start |
| busy | output | 1 | Pointer lookup or streaming in progress |
| done | output | 1 | Last page load finished |
| error | output | 1 | Sticky invalid-pointer flag |
| fl_addr | output | 24 | Flash word address |
| fl_rd | output | 1 | Flash read strobe |
| fl_rdata | input | 16 | Flash read data |
| fl_rvalid | input | 1 | Flash read data valid |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Downstream accepts word |
| out_data | output | 16 | Stream word |
| out_last | output | 1 | Final word of the page |
| out_nibs | output | 3 | Valid nibbles in this word (1..4) |

## Verification
The embedded assertions assume the flash answers each strobe with exactly one `fl_rvalid` pulse, never unprompted and never in the same cycle as the strobe. They also assume `out_ready` is a plain level that may change on any cycle. The bench flash model returns data a fixed two cycles after each strobe and never produces a spontaneous valid. The stimulus varies `out_ready` both as always-high and as a one-in-three pattern, so the hold rule is exercised under real stalls. Pointer records are written into the model's option window before each start. Invalid records are only presented in cases where the sticky error is the expected outcome.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int PFS_START_W = 23;
  localparam int PFS_CNT_W   = 25;

  typedef struct packed {
    logic [PFS_CNT_W-1:0]   count;
    logic [PFS_START_W-1:0] start;
  } pfs_ptr_t;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_PTR,
    SEQ_STREAM,
    SEQ_DONE,
    SEQ_ERR
  } pfs_seq_t;
endpackage

// File: rtl/pfs_ptr_reader.sv
module pfs_ptr_reader
  import pfs_pkg::*;
#(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int PAGE_W    = 3,
  parameter int START_W   = PFS_START_W,
  parameter int CNT_W     = PFS_CNT_W,
  parameter logic [AW-1:0] OPT_BASE  = 24'h008000,
  parameter logic [AW-1:0] DATA_BASE = 24'h008020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [PAGE_W-1:0] page,
  output logic              rd,
  output logic [AW-1:0]     addr,
  input  logic [DW-1:0]     rdata,
  input  logic              rvalid,
  output logic              ptr_done,
  output pfs_ptr_t          ptr,
  output logic              ptr_ok
);
  localparam int REC_WORDS = 4;
  localparam int IDX_W     = $clog2(REC_WORDS);
  localparam int SHI_W     = START_W - DW;
  localparam int CHI_W     = CNT_W - DW;
  localparam int WIN_WORDS = REC_WORDS << PAGE_W;
  localparam logic [START_W-1:0] START_MIN = START_W'(DATA_BASE);

  logic              active_q, pend_q, done_q;
  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DW-1:0]     st_lo_q, ct_lo_q;
  logic [SHI_W-1:0]  st_hi_q;
  logic [CHI_W-1:0]  ct_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
      page_q   <= '0;
      idx_q    <= '0;
      st_lo_q  <= '0;
      st_hi_q  <= '0;
      ct_lo_q  <= '0;
      ct_hi_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (go && !active_q) begin
        active_q <= 1'b1;
        page_q   <= page;
        idx_q    <= '0;
      end else if (active_q) begin
        if (rd) pend_q <= 1'b1;
        if (pend_q && rvalid) begin
          pend_q <= 1'b0;
          case (idx_q)
            2'd0:    st_lo_q <= rdata;
            2'd1:    st_hi_q <= rdata[SHI_W-1:0];
            2'd2:    ct_lo_q <= rdata;
            default: ct_hi_q <= rdata[CHI_W-1:0];
          endcase
          if (idx_q == IDX_W'(REC_WORDS - 1)) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  assign rd        = active_q && !pend_q;
  assign addr      = OPT_BASE + AW'({page_q, idx_q});
  assign ptr_done  = done_q;
  assign ptr.start = {st_hi_q, st_lo_q};
  assign ptr.count = {ct_hi_q, ct_lo_q};
  assign ptr_ok    = (ptr.count != '0) && (ptr.count != '1) && (ptr.start >= START_MIN);

  // R2: pointer reads stay inside the option-word window
  a_r2_opt_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> (addr >= OPT_BASE) && (addr < OPT_BASE + AW'(WIN_WORDS)));
  // R4: a record completes only on a returned flash word
  a_r4_done_on_return: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ptr_done) |-> $past(rvalid));
endmodule

// File: rtl/pfs_word_streamer.sv
module pfs_word_streamer #(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int START_W = 23,
  parameter int CNT_W   = 25,
  parameter logic [AW-1:0] DATA_BASE = 24'h008020,
  localparam int NPW     = DW / 4,
  localparam int LOG_NPW = $clog2(NPW),
  localparam int NIB_W   = LOG_NPW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [START_W-1:0] start_addr,
  input  logic [CNT_W-1:0]   nib_count,
  output logic               rd,
  output logic [AW-1:0]      addr,
  input  logic [DW-1:0]      rdata,
  input  logic               rvalid,
  output logic               o_valid,
  input  logic               o_ready,
  output logic [DW-1:0]      o_data,
  output logic               o_last,
  output logic [NIB_W-1:0]   o_nibs,
  output logic               seq_done
);
  logic [AW-1:0]      addr_q;
  logic [CNT_W-1:0]   left_q;
  logic [NIB_W-1:0]   tail_q;
  logic               pend_q, valid_q, last_q, done_q;
  logic [DW-1:0]      data_q;
  logic [NIB_W-1:0]   nibs_q;
  logic [CNT_W:0]     words_rounded;
  logic [LOG_NPW-1:0] rem;
  logic [NIB_W-1:0]   tail_d;

  assign words_rounded = ({1'b0, nib_count} + (CNT_W+1)'(NPW - 1)) >> LOG_NPW;
  assign rem           = nib_count[LOG_NPW-1:0];
  assign tail_d        = (rem == '0) ? NIB_W'(NPW) : NIB_W'(rem);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      left_q  <= '0;
      tail_q  <= '0;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      nibs_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        addr_q  <= AW'(start_addr);
        left_q  <= CNT_W'(words_rounded);
        tail_q  <= tail_d;
        pend_q  <= 1'b0;
        valid_q <= 1'b0;
      end else begin
        if (rd) pend_q <= 1'b1;
        if (pend_q && rvalid) begin
          pend_q  <= 1'b0;
          valid_q <= 1'b1;
          data_q  <= rdata;
          last_q  <= (left_q == CNT_W'(1));
          nibs_q  <= (left_q == CNT_W'(1)) ? tail_q : NIB_W'(NPW);
          left_q  <= left_q - 1'b1;
          addr_q  <= addr_q + 1'b1;
        end
        if (valid_q && o_ready) begin
          valid_q <= 1'b0;
          if (last_q) done_q <= 1'b1;
        end
      end
    end
  end

  assign rd       = (left_q != '0) && !pend_q && !valid_q;
  assign addr     = addr_q;
  assign o_valid  = valid_q;
  assign o_data   = data_q;
  assign o_last   = last_q;
  assign o_nibs   = nibs_q;
  assign seq_done = done_q;

  // R8: a stalled word is held unchanged
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_data) && $stable(o_last) && $stable(o_nibs));
  // R7: nibble count range, full words before the last
  a_r7_nib_range: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_nibs != '0) && (o_nibs <= NIB_W'(NPW)) && (o_last || o_nibs == NIB_W'(NPW)));
  // R6: data reads never reach below the configuration data floor
  a_r6_data_floor: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> addr >= DATA_BASE);
endmodule

// File: rtl/pfs_port_mux.sv
module pfs_port_mux #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_data,
  input  logic          p_rd,
  input  logic [AW-1:0] p_addr,
  input  logic          d_rd,
  input  logic [AW-1:0] d_addr,
  input  logic          rvalid,
  output logic          p_rvalid,
  output logic          d_rvalid,
  output logic          fl_rd,
  output logic [AW-1:0] fl_addr
);
  assign fl_rd    = sel_data ? d_rd : p_rd;
  assign fl_addr  = sel_data ? d_addr : p_addr;
  assign p_rvalid = rvalid && !sel_data;
  assign d_rvalid = rvalid && sel_data;

  // R4: the two requesters never strobe together
  a_r4_single_master: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_rd && d_rd));
endmodule

// File: rtl/pfs_page_fetch.sv
module pfs_page_fetch
  import pfs_pkg::*;
#(
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int PAGE_W = 3,
  parameter logic [AW-1:0] OPT_BASE  = 24'h008000,
  parameter logic [AW-1:0] DATA_BASE = 24'h008020,
  localparam int NIB_W = $clog2(DW / 4) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] page_sel,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [AW-1:0]     fl_addr,
  output logic              fl_rd,
  input  logic [DW-1:0]     fl_rdata,
  input  logic              fl_rvalid,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_last,
  output logic [NIB_W-1:0]  out_nibs
);
  pfs_seq_t      st_q;
  logic          ptr_go, str_go;
  logic          p_rd, d_rd, p_rvalid, d_rvalid;
  logic [AW-1:0] p_addr, d_addr;
  logic          ptr_done, ptr_ok, str_done;
  pfs_ptr_t      ptr;

  assign ptr_go = start && (st_q == SEQ_IDLE || st_q == SEQ_DONE);
  assign str_go = (st_q == SEQ_PTR) && ptr_done && ptr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= SEQ_IDLE;
    end else begin
      case (st_q)
        SEQ_IDLE, SEQ_DONE: if (ptr_go) st_q <= SEQ_PTR;
        SEQ_PTR:    if (ptr_done) st_q <= ptr_ok ? SEQ_STREAM : SEQ_ERR;
        SEQ_STREAM: if (str_done) st_q <= SEQ_DONE;
        default:    st_q <= SEQ_ERR;
      endcase
    end
  end

  assign busy  = (st_q == SEQ_PTR) || (st_q == SEQ_STREAM);
  assign done  = (st_q == SEQ_DONE);
  assign error = (st_q == SEQ_ERR);

  pfs_ptr_reader #(
    .AW(AW), .DW(DW), .PAGE_W(PAGE_W),
    .START_W(PFS_START_W), .CNT_W(PFS_CNT_W),
    .OPT_BASE(OPT_BASE), .DATA_BASE(DATA_BASE)
  ) u_ptr (
    .clk(clk), .rst_n(rst_n), .go(ptr_go), .page(page_sel),
    .rd(p_rd), .addr(p_addr), .rdata(fl_rdata), .rvalid(p_rvalid),
    .ptr_done(ptr_done), .ptr(ptr), .ptr_ok(ptr_ok)
  );

  pfs_word_streamer #(
    .AW(AW), .DW(DW), .START_W(PFS_START_W), .CNT_W(PFS_CNT_W),
    .DATA_BASE(DATA_BASE)
  ) u_str (
    .clk(clk), .rst_n(rst_n), .go(str_go),
    .start_addr(ptr.start), .nib_count(ptr.count),
    .rd(d_rd), .addr(d_addr), .rdata(fl_rdata), .rvalid(d_rvalid),
    .o_valid(out_valid), .o_ready(out_ready), .o_data(out_data),
    .o_last(out_last), .o_nibs(out_nibs), .seq_done(str_done)
  );

  pfs_port_mux #(.AW(AW)) u_mux (
    .clk(clk), .rst_n(rst_n), .sel_data(st_q == SEQ_STREAM),
    .p_rd(p_rd), .p_addr(p_addr), .d_rd(d_rd), .d_addr(d_addr),
    .rvalid(fl_rvalid), .p_rvalid(p_rvalid), .d_rvalid(d_rvalid),
    .fl_rd(fl_rd), .fl_addr(fl_addr)
  );

  // R5: error never clears without reset
  a_r5_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);
  // R5: a locked sequencer is silent on both ports
  a_r5_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !out_valid && !fl_rd);
  // R4: a strobe is never followed directly by another
  a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd |=> !fl_rd);
  // R9: done rises two cycles after the final word transfers
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready && out_last, 2));
endmodule

// File: tb/pfs_page_fetch_test.sv
module pfs_page_fetch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  page_sel = 3'd0;
  logic        busy, done, error;
  logic [23:0] fl_addr;
  logic        fl_rd;
  logic [15:0] fl_rdata;
  logic        fl_rvalid;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_last;
  logic [2:0]  out_nibs;

  int errs = 0;
  int nchk = 0;

  always #5 clk = ~clk;

  pfs_page_fetch uut (
    .clk(clk), .rst_n(rst_n), .start(start), .page_sel(page_sel),
    .busy(busy), .done(done), .error(error),
    .fl_addr(fl_addr), .fl_rd(fl_rd), .fl_rdata(fl_rdata), .fl_rvalid(fl_rvalid),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_nibs(out_nibs)
  );

  // flash model: fixed two-cycle read latency, reads logged
  logic [15:0] opt_mem [0:31];
  logic [23:0] log_addr [0:255];
  int          log_n = 0;
  int          r4_viol = 0;
  int          lat_cnt = 0;
  logic [23:0] cap_addr = '0;

  function automatic logic [15:0] mem_word(input logic [23:0] a);
    if (a >= 24'h008000 && a < 24'h008020) return opt_mem[a - 24'h008000];
    return a[15:0] ^ 16'hC35A;
  endfunction

  always @(posedge clk) begin
    fl_rvalid <= 1'b0;
    if (!rst_n) begin
      lat_cnt <= 0;
    end else begin
      if (lat_cnt != 0) begin
        lat_cnt <= lat_cnt - 1;
        if (lat_cnt == 1) begin
          fl_rvalid <= 1'b1;
          fl_rdata  <= mem_word(cap_addr);
        end
      end
      if (fl_rd) begin
        if (lat_cnt != 0) r4_viol <= r4_viol + 1;
        cap_addr <= fl_addr;
        lat_cnt  <= 2;
        if (log_n < 256) log_addr[log_n] <= fl_addr;
        log_n <= log_n + 1;
      end
    end
  end

  initial begin
    fl_rdata  = '0;
    fl_rvalid = 1'b0;
    for (int i = 0; i < 32; i++) opt_mem[i] = 16'hFFFF;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // pointer record with junk in the ignored upper bits
  task automatic set_ptr(input int pg, input logic [22:0] st, input logic [24:0] cnt,
                         input logic [8:0] junk_s, input logic [6:0] junk_c);
    opt_mem[pg*4+0] = st[15:0];
    opt_mem[pg*4+1] = {junk_s, st[22:16]};
    opt_mem[pg*4+2] = cnt[15:0];
    opt_mem[pg*4+3] = {junk_c, cnt[24:16]};
  endtask

  task automatic run_page(input int pg, input logic [22:0] st, input int nibs,
                          input bit bp, input bit poke, input string tag);
    int base, nw, got, k;
    bit pv, pr, pl, stall_bad;
    logic [15:0] pd;
    logic [2:0]  pn;
    logic [15:0] rx_d [0:63];
    logic        rx_l [0:63];
    logic [2:0]  rx_n [0:63];
    base = log_n; nw = (nibs + 3) / 4; got = 0; k = 0;
    pv = 0; pr = 0; pl = 0; pd = '0; pn = '0; stall_bad = 0;
    @(negedge clk);
    page_sel = 3'(pg); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    page_sel = ~3'(pg); // R2: must be ignored from here
    check(busy == 1'b1, {"R9 busy during ", tag}, busy, 1);
    while (!done && k < 3000) begin
      @(negedge clk);
      k++;
      start = (poke && k == 12);
      if (poke && k == 12) page_sel = 3'd0;
      if (pv && !pr) begin
        if (!(out_valid && out_data == pd && out_last == pl && out_nibs == pn)) stall_bad = 1;
      end
      out_ready = bp ? (k % 3 == 2) : 1'b1;
      if (out_valid && out_ready && got < 64) begin
        rx_d[got] = out_data; rx_l[got] = out_last; rx_n[got] = out_nibs;
        got++;
      end
      pv = out_valid; pr = out_ready; pd = out_data; pl = out_last; pn = out_nibs;
    end
    start = 1'b0;
    check(k < 3000, {"R9 sequence finished ", tag}, k, 0);
    check(!stall_bad, {"R8 stalled word held ", tag}, stall_bad, 0);
    for (int i = 0; i < 4; i++)
      check(log_addr[base+i] == 24'h008000 + 24'(pg*4 + i), {"R2 option read address ", tag},
            log_addr[base+i], 24'h008000 + pg*4 + i);
    check(got == nw, {"R6 word count ", tag}, got, nw);
    check(log_n - base == 4 + nw, {"R10 total reads ", tag}, log_n - base, 4 + nw);
    for (int i = 0; i < nw && i < got; i++) begin
      logic [23:0] ea;
      ea = 24'(st) + 24'(i);
      check(log_addr[base+4+i] == ea, {"R6 data read address ", tag}, log_addr[base+4+i], ea);
      check(rx_d[i] == mem_word(ea), {"R3 R6 data word ", tag}, rx_d[i], mem_word(ea));
      check(rx_l[i] == (i == nw-1), {"R7 last flag ", tag}, rx_l[i], (i == nw-1));
      check(rx_n[i] == ((i == nw-1 && nibs % 4 != 0) ? 3'(nibs % 4) : 3'd4),
            {"R7 nibble count ", tag}, rx_n[i],
            (i == nw-1 && nibs % 4 != 0) ? nibs % 4 : 4);
    end
    check(done == 1'b1 && busy == 1'b0 && error == 1'b0, {"R9 done state ", tag},
          {done, busy, error}, 3'b100);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check({busy, done, error, out_valid, fl_rd} == 5'b0, "R1 reset outputs",
          {busy, done, error, out_valid, fl_rd}, 0);
  endtask

  task automatic t_basic();
    set_ptr(2, 23'h008100, 25'd10, 9'h000, 7'h00);
    run_page(2, 23'h008100, 10, 1'b0, 1'b0, "basic");
  endtask

  task automatic t_backpressure();
    // R3 junk upper bits, R8 stalls, R10 start while busy, boundary start
    set_ptr(5, 23'h008020, 25'd24, 9'h1A5, 7'h55);
    run_page(5, 23'h008020, 24, 1'b1, 1'b1, "backpressure");
  endtask

  task automatic t_single_and_restart();
    set_ptr(0, 23'h7ABCDE, 25'd1, 9'h1FF, 7'h7F);
    run_page(0, 23'h7ABCDE, 1, 1'b0, 1'b0, "single nibble");
    set_ptr(1, 23'h00A000, 25'd7, 9'h000, 7'h00);
    run_page(1, 23'h00A000, 7, 1'b1, 1'b0, "restart after done");
  endtask

  task automatic t_invalid(input int pg, input logic [22:0] st, input logic [24:0] cnt,
                           input string tag);
    int base;
    bit seen_v;
    do_reset();
    set_ptr(pg, st, cnt, 9'h000, 7'h00);
    set_ptr(3, 23'h009000, 25'd8, 9'h000, 7'h00);
    base = log_n; seen_v = 0;
    @(negedge clk);
    page_sel = 3'(pg); start = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk) if (out_valid) seen_v = 1;
    check(error == 1'b1 && busy == 1'b0, {"R5 error raised ", tag}, {error, busy}, 2'b10);
    check(log_n - base == 4, {"R5 no data reads ", tag}, log_n - base, 4);
    page_sel = 3'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk) if (out_valid) seen_v = 1;
    check(error == 1'b1, {"R5 error sticky after start ", tag}, error, 1);
    check(log_n - base == 4, {"R5 start ignored in error ", tag}, log_n - base, 4);
    check(!seen_v, {"R5 no stream output ", tag}, seen_v, 0);
    do_reset();
    @(negedge clk);
    check(error == 1'b0, {"R1 R5 reset clears error ", tag}, error, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errs++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_backpressure();
    t_single_and_restart();
    t_invalid(7, 23'h008200, 25'd0, "zero count");
    t_invalid(6, 23'h008200, 25'h1FFFFFF, "erased count");
    t_invalid(4, 23'h00801F, 25'd8, "start in option area");
    check(r4_viol == 0, "R4 single outstanding read", r4_viol, 0);
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule